// File: doc/BRIEF.md
# Banked Vectored Interrupt Controller

This block collects 96 level-sensitive interrupt sources, organised as three banks of 32, and presents them to a processor as two request lines: one for normal interrupts and one for fast interrupts. Each source has a sticky pending flag, an enable gate, a mask gate, a route bit that picks between the normal and the fast line, and a two-bit priority. A vector register names the winning normal-line source so that a handler can jump straight to it.

Software reaches every register through a simple 32-bit register port: a write strobe, a byte address and write data, with read data returned combinationally for the current address. Pending flags are cleared by writing ones to them. The vector read returns a programmable base plus four times the winning source number, or zero when nothing is eligible. Source 0 therefore can never be delivered.

Source n lives in bank n>>5 at bit n&31. Its priority field sits in priority word n>>4 at bits 2*(n&15)+1 down to 2*(n&15).

Top module: `banked_vic`

## Requirements
- R1: After a synchronous active-low reset, every pending, route, enable, mask and priority bit is 0, the base, protection and NMI words are 0, both request outputs are low and the vector read (address 0x00) returns 0.
- R2: A source that is high at a clock edge sets its pending flag at that edge: in the normal pending bank (0x10 + 4*bank) when its route bit is 0, in the fast pending bank (0x20 + 4*bank) when its route bit is 1. The flag stays set after the source falls.
- R3: Writing a pending bank clears each flag whose write-data bit is 1 and leaves flags under 0 bits untouched; a source still high during the clearing write sets its flag again one cycle after the write.
- R4: A pending source is eligible only while its enable bit (0x40 + 4*bank) is 1 and its mask bit (0x50 + 4*bank) is 0; pending flags are captured regardless of enable and mask.
- R5: `irq_o` is high exactly when some eligible source with a normal-bank flag exists, and `fiq_o` exactly when some eligible source with a fast-bank flag exists; route bits live at 0x30 + 4*bank.
- R6: Reading address 0x00 returns base (0x04) plus 4 times the number of the eligible normal-bank source with the largest priority value (3 highest, 0 lowest), priority words at 0x80 + 4*k; it returns 0 when no such source exists.
- R7: Among eligible normal-bank sources of equal priority the lowest source number wins.
- R8: Source 0 never drives a request output and never appears in the vector, even when pending, enabled and unmasked; its pending flag is still readable.
- R9: The base (0x04), protection (0x08) and NMI control (0x0C) words, and the route, enable, mask and priority words, read back what was last written; every other address reads 0 and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 96 | Level interrupt sources, bit n is source n |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench chases the clear-while-asserted case, where a design that let capture win over the clear would never show the flag drop, and one that blocked capture too long would lose the re-arm a cycle later. Equal-priority contests, including one against a bank-two source, expose an arbiter that favours the highest number or the last bank scanned. Source 0 is made fully eligible to catch a design that raises `irq_o` with a vector of zero, and the route bit is flipped so that a source landing in the wrong bank or on the wrong line shows up both in the read-back and on the outputs.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned FIELD_PER_WORD = 16;

    // Register word offsets (byte addresses)
    localparam int unsigned OFS_VEC   = 'h00;
    localparam int unsigned OFS_BASE  = 'h04;
    localparam int unsigned OFS_PROT  = 'h08;
    localparam int unsigned OFS_NMI   = 'h0C;
    localparam int unsigned OFS_IPEND = 'h10;
    localparam int unsigned OFS_FPEND = 'h20;
    localparam int unsigned OFS_ROUTE = 'h30;
    localparam int unsigned OFS_EN    = 'h40;
    localparam int unsigned OFS_MASK  = 'h50;
    localparam int unsigned OFS_PRIO  = 'h80;
endpackage

// File: rtl/vic_pend.sv
module vic_pend #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cap_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] pend_o
);
    logic [W-1:0] pend_d, pend_q;

    // A clear in the same cycle beats a capture; capture resumes next edge.
    always_comb begin
        pend_d = (pend_q | cap_i) & ~clr_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((pend_q & $past(clr_i)) == '0)); // R3

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~pend_q & $past(pend_q) & ~$past(clr_i)) == '0)); // R2
endmodule

// File: rtl/vic_arb.sv
module vic_arb #(
    parameter int unsigned N      = 96,
    parameter int unsigned PRIO_W = 2,
    localparam int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]        req_i,
    input  logic [N*PRIO_W-1:0] prio_i,
    output logic                valid_o,
    output logic [IDX_W-1:0]    idx_o
);
    logic [PRIO_W-1:0] best;

    // Scan from the top down; ">=" lets a lower number take over a tie.
    always_comb begin
        valid_o = 1'b0;
        best    = '0;
        idx_o   = '0;
        for (int n = N - 1; n >= 0; n--) begin
            if (req_i[n] && (!valid_o || prio_i[n*PRIO_W +: PRIO_W] >= best)) begin
                valid_o = 1'b1;
                best    = prio_i[n*PRIO_W +: PRIO_W];
                idx_o   = IDX_W'(n);
            end
        end
    end
endmodule

// File: rtl/banked_vic.sv
module banked_vic
    import vic_pkg::*;
#(
    parameter int unsigned NSRC   = 96,
    parameter int unsigned PRIO_W = 2,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o,
    output logic              fiq_o
);
    localparam int unsigned NBANK   = (NSRC + WORD_W - 1) / WORD_W;
    localparam int unsigned SRC_PAD = NBANK * WORD_W;
    localparam int unsigned NPRIO   = SRC_PAD / FIELD_PER_WORD;
    localparam int unsigned IDX_W   = $clog2(SRC_PAD);

    typedef struct packed {
        logic [WORD_W-1:0]       base;
        logic [WORD_W-1:0]       prot;
        logic [WORD_W-1:0]       nmi;
        logic [SRC_PAD-1:0]      route;
        logic [SRC_PAD-1:0]      en;
        logic [SRC_PAD-1:0]      mask;
        logic [NPRIO*WORD_W-1:0] prio;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [SRC_PAD-1:0] src_pad, ipend, fpend, iclr, fclr;
    logic [SRC_PAD-1:0] elig_i, elig_f;
    logic               arb_valid;
    logic [IDX_W-1:0]   arb_idx;
    logic [WORD_W-1:0]  vec;

    assign src_pad = SRC_PAD'(src_i);

    // Configuration next-state
    always_comb begin
        cfg_d = cfg_q;
        iclr  = '0;
        fclr  = '0;
        if (bus_we) begin
            if (bus_addr == ADDR_W'(OFS_BASE)) cfg_d.base = bus_wdata;
            if (bus_addr == ADDR_W'(OFS_PROT)) cfg_d.prot = bus_wdata;
            if (bus_addr == ADDR_W'(OFS_NMI))  cfg_d.nmi  = bus_wdata;
            for (int b = 0; b < NBANK; b++) begin
                if (bus_addr == ADDR_W'(OFS_ROUTE + 4*b)) cfg_d.route[b*WORD_W +: WORD_W] = bus_wdata;
                if (bus_addr == ADDR_W'(OFS_EN + 4*b))    cfg_d.en[b*WORD_W +: WORD_W]    = bus_wdata;
                if (bus_addr == ADDR_W'(OFS_MASK + 4*b))  cfg_d.mask[b*WORD_W +: WORD_W]  = bus_wdata;
                if (bus_addr == ADDR_W'(OFS_IPEND + 4*b)) iclr[b*WORD_W +: WORD_W]        = bus_wdata;
                if (bus_addr == ADDR_W'(OFS_FPEND + 4*b)) fclr[b*WORD_W +: WORD_W]        = bus_wdata;
            end
            for (int p = 0; p < NPRIO; p++) begin
                if (bus_addr == ADDR_W'(OFS_PRIO + 4*p)) cfg_d.prio[p*WORD_W +: WORD_W] = bus_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // Pending banks, one pair per bank
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        vic_pend #(.W(WORD_W)) u_ipend (
            .clk    (clk),
            .rst_n  (rst_n),
            .cap_i  (src_pad[b*WORD_W +: WORD_W] & ~cfg_q.route[b*WORD_W +: WORD_W]),
            .clr_i  (iclr[b*WORD_W +: WORD_W]),
            .pend_o (ipend[b*WORD_W +: WORD_W])
        );
        vic_pend #(.W(WORD_W)) u_fpend (
            .clk    (clk),
            .rst_n  (rst_n),
            .cap_i  (src_pad[b*WORD_W +: WORD_W] & cfg_q.route[b*WORD_W +: WORD_W]),
            .clr_i  (fclr[b*WORD_W +: WORD_W]),
            .pend_o (fpend[b*WORD_W +: WORD_W])
        );
    end

    // Gating; source 0 is reserved for "nothing pending"
    localparam logic [SRC_PAD-1:0] SRC0_BLOCK = SRC_PAD'(1);
    assign elig_i = ipend & cfg_q.en & ~cfg_q.mask & ~SRC0_BLOCK;
    assign elig_f = fpend & cfg_q.en & ~cfg_q.mask & ~SRC0_BLOCK;
    assign irq_o  = |elig_i;
    assign fiq_o  = |elig_f;

    vic_arb #(.N(SRC_PAD), .PRIO_W(PRIO_W)) u_arb (
        .req_i   (elig_i),
        .prio_i  (cfg_q.prio[SRC_PAD*PRIO_W-1:0]),
        .valid_o (arb_valid),
        .idx_o   (arb_idx)
    );

    assign vec = arb_valid ? cfg_q.base + {{(WORD_W-IDX_W-2){1'b0}}, arb_idx, 2'b00} : '0;

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_VEC))  bus_rdata = vec;
        if (bus_addr == ADDR_W'(OFS_BASE)) bus_rdata = cfg_q.base;
        if (bus_addr == ADDR_W'(OFS_PROT)) bus_rdata = cfg_q.prot;
        if (bus_addr == ADDR_W'(OFS_NMI))  bus_rdata = cfg_q.nmi;
        for (int b = 0; b < NBANK; b++) begin
            if (bus_addr == ADDR_W'(OFS_IPEND + 4*b)) bus_rdata = ipend[b*WORD_W +: WORD_W];
            if (bus_addr == ADDR_W'(OFS_FPEND + 4*b)) bus_rdata = fpend[b*WORD_W +: WORD_W];
            if (bus_addr == ADDR_W'(OFS_ROUTE + 4*b)) bus_rdata = cfg_q.route[b*WORD_W +: WORD_W];
            if (bus_addr == ADDR_W'(OFS_EN + 4*b))    bus_rdata = cfg_q.en[b*WORD_W +: WORD_W];
            if (bus_addr == ADDR_W'(OFS_MASK + 4*b))  bus_rdata = cfg_q.mask[b*WORD_W +: WORD_W];
        end
        for (int p = 0; p < NPRIO; p++) begin
            if (bus_addr == ADDR_W'(OFS_PRIO + 4*p)) bus_rdata = cfg_q.prio[p*WORD_W +: WORD_W];
        end
    end

    AST_IRQ_AGREES_ARB: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == arb_valid); // R5

    AST_WINNER_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        arb_valid |-> elig_i[arb_idx]); // R6

    AST_SRC0_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !(arb_valid && arb_idx == '0)); // R8

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(cfg_q)); // R9
endmodule

// File: tb/sim_banked_vic.sv
module sim_banked_vic;
    localparam int CLK_P = 10;
    localparam int NS    = 96;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int checks = 0;
    int errors = 0;
    bit chk_on = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    banked_vic u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    // ---------------- reference model ----------------
    logic [NS-1:0] m_ip, m_fp, m_rt, m_en, m_mk;
    logic [1:0]    m_pr [NS];
    logic [31:0]   m_base, m_prot, m_nmi;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ip <= '0; m_fp <= '0; m_rt <= '0; m_en <= '0; m_mk <= '0;
            m_base <= '0; m_prot <= '0; m_nmi <= '0;
            for (int n = 0; n < NS; n++) m_pr[n] <= 2'd0;
        end else begin
            for (int n = 0; n < NS; n++) begin
                automatic int bk = n / 32;
                automatic int bt = n % 32;
                automatic bit ci = bus_we && bus_addr == 8'(16 + 4*bk) && bus_wdata[bt];
                automatic bit cf = bus_we && bus_addr == 8'(32 + 4*bk) && bus_wdata[bt];
                m_ip[n] <= (m_ip[n] | (src[n] & ~m_rt[n])) & ~ci;
                m_fp[n] <= (m_fp[n] | (src[n] &  m_rt[n])) & ~cf;
            end
            if (bus_we) begin
                if (bus_addr == 8'h04) m_base <= bus_wdata;
                if (bus_addr == 8'h08) m_prot <= bus_wdata;
                if (bus_addr == 8'h0C) m_nmi  <= bus_wdata;
                for (int b = 0; b < 3; b++) begin
                    if (bus_addr == 8'(48 + 4*b)) m_rt[32*b +: 32] <= bus_wdata;
                    if (bus_addr == 8'(64 + 4*b)) m_en[32*b +: 32] <= bus_wdata;
                    if (bus_addr == 8'(80 + 4*b)) m_mk[32*b +: 32] <= bus_wdata;
                end
                for (int k = 0; k < 6; k++)
                    if (bus_addr == 8'(128 + 4*k))
                        for (int f = 0; f < 16; f++) m_pr[16*k + f] <= bus_wdata[2*f +: 2];
            end
        end
    end

    function automatic logic [31:0] exp_vec();
        int best = -1;
        int bp = 0;
        for (int n = 1; n < NS; n++)
            if (m_ip[n] && m_en[n] && !m_mk[n] && (best < 0 || int'(m_pr[n]) > bp)) begin
                best = n; bp = int'(m_pr[n]);
            end
        return (best < 0) ? 32'd0 : m_base + 32'(4 * best);
    endfunction

    function automatic bit exp_line(bit fast);
        for (int n = 1; n < NS; n++)
            if ((fast ? m_fp[n] : m_ip[n]) && m_en[n] && !m_mk[n]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] exp_rd(logic [7:0] a);
        logic [31:0] r = '0;
        if (a == 8'h00) r = exp_vec();
        if (a == 8'h04) r = m_base;
        if (a == 8'h08) r = m_prot;
        if (a == 8'h0C) r = m_nmi;
        for (int b = 0; b < 3; b++) begin
            if (a == 8'(16 + 4*b)) r = m_ip[32*b +: 32];
            if (a == 8'(32 + 4*b)) r = m_fp[32*b +: 32];
            if (a == 8'(48 + 4*b)) r = m_rt[32*b +: 32];
            if (a == 8'(64 + 4*b)) r = m_en[32*b +: 32];
            if (a == 8'(80 + 4*b)) r = m_mk[32*b +: 32];
        end
        for (int k = 0; k < 6; k++)
            if (a == 8'(128 + 4*k))
                for (int f = 0; f < 16; f++) r[2*f +: 2] = m_pr[16*k + f];
        return r;
    endfunction

    // ---------------- checking ----------------
    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, act, exp);
        end
    endtask

    // Every-clock comparison of outputs against the model (R5, R6)
    always @(negedge clk) begin
        if (chk_on) begin
            chk("R5 irq_o", 32'(irq_o), 32'(exp_line(1'b0)));
            chk("R5 fiq_o", 32'(fiq_o), 32'(exp_line(1'b1)));
            if (!bus_we && bus_addr == 8'h00) chk("R6 vector", bus_rdata, exp_vec());
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        tick();
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
    endtask

    task automatic rd(logic [7:0] a, string tag);
        tick();
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp_rd(a));
        bus_addr = 8'h00;
    endtask

    task automatic rd_lit(logic [7:0] a, logic [31:0] e, string tag);
        tick();
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, e);
        bus_addr = 8'h00;
    endtask

    task automatic pulse(int n);
        tick(); src[n] = 1'b1;
        tick(); src[n] = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        chk_on = 1'b1;

        // R1: reset state
        chk("R1 irq_o low", 32'(irq_o), 32'd0);
        chk("R1 fiq_o low", 32'(fiq_o), 32'd0);
        rd_lit(8'h00, 32'd0, "R1 vector");
        rd_lit(8'h10, 32'd0, "R1 pending");
        rd_lit(8'h28, 32'd0, "R1 fast pending");
        rd_lit(8'h44, 32'd0, "R1 enable");
        rd_lit(8'h58, 32'd0, "R1 mask");
        rd_lit(8'h94, 32'd0, "R1 priority");

        // R9: plain storage and unmapped addresses
        wr(8'h08, 32'h1);
        wr(8'h0C, 32'hA5);
        wr(8'h70, 32'hFFFF_FFFF);
        rd_lit(8'h08, 32'h1, "R9 protection");
        rd_lit(8'h0C, 32'hA5, "R9 nmi");
        rd_lit(8'h70, 32'd0, "R9 unmapped");
        rd_lit(8'h98, 32'd0, "R9 past priority");

        // R2: capture and route
        pulse(5);
        rd_lit(8'h10, 32'h20, "R2 bank0 captured");
        wr(8'h34, 32'h100);
        rd(8'h34, "R9 route readback");
        pulse(40);
        rd_lit(8'h24, 32'h100, "R2 fast bank1");
        rd_lit(8'h14, 32'h0, "R2 normal bank1 empty");

        // R4: gating
        chk("R4 disabled no irq", 32'(irq_o), 32'd0);
        wr(8'h40, 32'h20);
        chk("R4 enabled irq", 32'(irq_o), 32'd1);
        rd_lit(8'h00, 32'd20, "R4 vector src5");
        wr(8'h50, 32'h20);
        chk("R4 masked no irq", 32'(irq_o), 32'd0);
        rd_lit(8'h10, 32'h20, "R4 still pending");
        wr(8'h50, 32'h0);

        // R6: priority winner and base offset
        wr(8'h80, (32'd3 << 14) | (32'd1 << 10));
        pulse(7);
        wr(8'h40, 32'hA0);
        rd_lit(8'h00, 32'd28, "R6 highest priority");
        wr(8'h04, 32'h1000);
        rd_lit(8'h00, 32'h101C, "R6 base added");
        wr(8'h04, 32'h0);

        // R7: ties go to lowest number
        wr(8'h80, (32'd3 << 14) | (32'd1 << 10) | (32'd3 << 18));
        pulse(9);
        wr(8'h40, 32'h2A0);
        rd_lit(8'h00, 32'd28, "R7 tie 7 vs 9");
        wr(8'h80, (32'd3 << 14) | (32'd1 << 10) | (32'd3 << 18) | (32'd3 << 6));
        pulse(3);
        wr(8'h40, 32'h2A8);
        rd_lit(8'h00, 32'd12, "R7 tie 3 wins");
        wr(8'h90, 32'd3 << 12);
        pulse(70);
        wr(8'h48, 32'h40);
        rd_lit(8'h00, 32'd12, "R7 tie across banks");
        wr(8'h10, 32'h2A8);
        rd_lit(8'h00, 32'd280, "R6 bank2 winner");
        wr(8'h18, 32'h40);

        // R8: source 0 never delivered
        wr(8'h40, 32'h1);
        pulse(0);
        rd_lit(8'h10, 32'h1, "R8 src0 pending");
        chk("R8 no irq", 32'(irq_o), 32'd0);
        rd_lit(8'h00, 32'd0, "R8 vector zero");
        wr(8'h10, 32'h1);

        // R3: clear while asserted, and zero bits untouched
        wr(8'h40, 32'h30);
        pulse(4);
        tick(); src[5] = 1'b1;
        tick(); bus_we = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h20;
        tick(); bus_we = 1'b0; bus_wdata = '0;
        #1; chk("R3 cleared after write", bus_rdata, 32'h10);
        tick(); #1; chk("R3 rearmed next cycle", bus_rdata, 32'h30);
        bus_addr = 8'h00;
        src[5] = 1'b0;
        wr(8'h10, 32'h0);
        rd(8'h10, "R3 zero write no effect");
        wr(8'h10, 32'hFFFF_FFFF);
        rd_lit(8'h10, 32'h0, "R3 all cleared");

        // R5: fast line
        wr(8'h44, 32'h100);
        chk("R5 fiq high", 32'(fiq_o), 32'd1);
        rd_lit(8'h00, 32'd0, "R5 fast not in vector");
        wr(8'h24, 32'h100);
        chk("R5 fiq low", 32'(fiq_o), 32'd0);

        repeat (3) tick();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule